// File: doc/BRIEF.md
# Profiled Phase-Accumulator Tone Generator

This block is a numerically controlled oscillator for a digital upconverter or a test-tone source. A 32-bit phase accumulator advances by a programmable frequency tuning word on every clock, so the output frequency is FTW × f_clk / 2^32. For example, a 122.88 MHz clock and a 41 MHz tone need FTW = 0x556AAAAB. Before phase-to-amplitude conversion, a 14-bit phase offset is added to the accumulated phase with its MSB aligned to the accumulator MSB, which gives a step of 360/2^14 degrees. A pipelined CORDIC rotator turns the 16 most significant bits of the offset phase into a cosine and sine pair.

Both samples then pass through an unsigned 14-bit fractional amplitude scaler. A control bit can bypass the scaler, and while it is bypassed the scaler's product registers do not load. Eight profiles each hold their own phase offset and amplitude scale. A registered profile-select pin picks the active profile, and switching profiles never resets the accumulator. The block always drives the quadrature pair. In single-tone mode it also drives a third output that carries either the sine or the cosine.

Configuration arrives on a parallel write port with a 4-bit address and 32-bit data.

Top module: `nco_tone_gen`

## Requirements
- R1: After each clock edge without reset, the accumulator equals its previous value plus the stored tuning word, modulo 2^32.
- R2: Write map (wrEn high at a clock edge):
  - Address 0 holds the tuning word.
  - Address 1 is the control register: bit 0 bypasses the scaler, bit 1 enables single-tone mode, bit 2 selects sine (1) or cosine (0) for the tone output.
  - Addresses 8 to 15 hold profile 0 to 7: bits [13:0] are the phase offset and bits [29:16] are the amplitude scale.
- R3: Bit 31 of a tuning-word write is ignored and stored as 0, so the stored word never exceeds 2^31 − 1.
- R4: The conversion phase is bits [31:16] of (accumulator + phase offset × 2^18).
- R5: With the scaler bypassed, cosOut and sinOut equal 32752·cos(2π·p/65536) and 32752·sin(2π·p/65536) within ±12 LSB. Here p is the conversion phase formed from the register state present 18 clock edges earlier.
- R6: With the scaler active, each output is the unscaled value × scale / 2^14 (within ±12 LSB). While the scaler is bypassed, its product registers hold their values.
- R7: profileSel is registered, and the registered value picks which of the eight profiles supplies the phase offset and the scale.
- R8: In single-tone mode, toneOut equals sinOut when the select bit is 1 and cosOut when it is 0.
- R9: Outside single-tone mode, toneOut is 0.
- R10: A new tuning word, offset or profile acts from the next clock edge, and the accumulator is not reset, so the phase stays continuous.
- R11: Synchronous reset clears the accumulator, the tuning word, the control bits, all profiles and the profile register, and it drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Register write data |
| profileSel | input | 3 | Active profile request |
| cosOut | output | 16 | Signed cosine sample |
| sinOut | output | 16 | Signed sine sample |
| toneOut | output | 16 | Signed single-tone sample, or 0 |

## Verification
The assertions check several rules on every cycle:
- the accumulator step (R1);
- the clearing of bit 31 on a tuning-word write (R3);
- that the product registers hold while the scaler is bypassed (R6);
- the routing of the tone output in both modes (R8, R9);
- that reset clears the accumulator (R11).

The waveform values themselves can only be shown by the bench's scenarios. These are the absolute phase, the offset alignment, the profile selection, the scale arithmetic and the 18-cycle alignment between a register change and its effect on the samples. The bench reproduces the phase from its own model of the register state and compares the outputs against ideal trigonometric values.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ACC_W   = 32;
  localparam int OFS_W   = 14;
  localparam int ASF_W   = 14;
  localparam int SMP_W   = 16;
  localparam int N_PROF  = 8;
  localparam int PROF_W  = $clog2(N_PROF);
  localparam int ADDR_W  = 4;
  localparam int ASF_LSB = 16;
  localparam int STAGES  = 14;
  localparam int ZF      = 4;

  localparam logic [ADDR_W-1:0] ADDR_FTW  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(1);
  localparam int PROF_BASE = 8;

  // Settings the control half hands to the datapath.
  typedef struct packed {
    logic [ACC_W-1:0] ftw;
    logic [OFS_W-1:0] pow;
    logic [ASF_W-1:0] asf;
    logic             mulEn;
    logic             singleTone;
    logic             toneSine;
  } nco_strobe_t;

  // Settings that travel down the pipe next to the phase.
  typedef struct packed {
    logic [ASF_W-1:0] asf;
    logic             mulEn;
    logic             singleTone;
    logic             toneSine;
  } nco_side_t;

  // atan(2^-i) expressed in units of one turn / 2^(SMP_W+ZF).
  function automatic int atanStep(input int i);
    case (i)
      0:  return 131072;
      1:  return 77376;
      2:  return 40884;
      3:  return 20753;
      4:  return 10417;
      5:  return 5213;
      6:  return 2607;
      7:  return 1304;
      8:  return 652;
      9:  return 326;
      10: return 163;
      11: return 81;
      12: return 41;
      13: return 20;
      14: return 10;
      15: return 5;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ACC_W-1:0]  wrData,
  input  logic [PROF_W-1:0] profileSel,
  output nco_strobe_t       strobes
);
  logic [ACC_W-1:0]  ftwReg;
  logic              bypassReg;
  logic              toneModeReg;
  logic              sineSelReg;
  logic [PROF_W-1:0] profReg;
  logic [OFS_W-1:0]  powBank [N_PROF];
  logic [ASF_W-1:0]  asfBank [N_PROF];

  always_ff @(posedge clk) begin
    if (rst) begin
      ftwReg      <= '0;
      bypassReg   <= 1'b0;
      toneModeReg <= 1'b0;
      sineSelReg  <= 1'b0;
      profReg     <= '0;
    end else begin
      profReg <= profileSel;
      if (wrEn && wrAddr == ADDR_FTW)
        ftwReg <= {1'b0, wrData[ACC_W-2:0]};
      if (wrEn && wrAddr == ADDR_CTRL) begin
        bypassReg   <= wrData[0];
        toneModeReg <= wrData[1];
        sineSelReg  <= wrData[2];
      end
    end
  end

  for (genvar g = 0; g < N_PROF; g++) begin : g_prof
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PROF_BASE + g);
    always_ff @(posedge clk) begin
      if (rst) begin
        powBank[g] <= '0;
        asfBank[g] <= '0;
      end else if (wrEn && wrAddr == MY_ADDR) begin
        powBank[g] <= wrData[OFS_W-1:0];
        asfBank[g] <= wrData[ASF_LSB +: ASF_W];
      end
    end
  end

  always_comb begin
    strobes.ftw        = ftwReg;
    strobes.pow        = powBank[profReg];
    strobes.asf        = asfBank[profReg];
    strobes.mulEn      = ~bypassReg;
    strobes.singleTone = toneModeReg;
    strobes.toneSine   = sineSelReg;
  end
endmodule

// File: rtl/nco_cordic.sv
module nco_cordic
  import nco_pkg::*;
#(
  parameter int PW    = SMP_W,
  parameter int NSTG  = STAGES,
  parameter int FRAC  = 3,
  parameter int ZFRAC = ZF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PW-1:0]        phaseIn,
  output logic signed [PW-1:0] cosRaw,
  output logic signed [PW-1:0] sinRaw
);
  localparam int XW  = PW + FRAC + 2;
  localparam int ZW  = PW + ZFRAC + 1;
  localparam int AMP = (((1 << (PW - 1)) - 1) * 607) / 1000;
  localparam logic signed [XW-1:0] X0 = XW'(AMP << FRAC);
  localparam logic signed [XW-1:0] POS_LIM = XW'(((1 << (PW - 1)) - 1) << FRAC);
  localparam logic signed [XW-1:0] NEG_LIM = -XW'((1 << (PW - 1)) << FRAC);

  logic signed [XW-1:0] xs [NSTG+1];
  logic signed [XW-1:0] ys [NSTG+1];
  logic signed [ZW-1:0] zs [NSTG+1];

  logic          flip;
  logic [PW-1:0] folded;
  assign flip   = phaseIn[PW-1] ^ phaseIn[PW-2];
  assign folded = flip ? {~phaseIn[PW-1], phaseIn[PW-2:0]} : phaseIn;

  // Fold the left half-plane onto the right by a 180 degree turn.
  always_ff @(posedge clk) begin
    if (rst) begin
      xs[0] <= '0;
      ys[0] <= '0;
      zs[0] <= '0;
    end else begin
      xs[0] <= flip ? -X0 : X0;
      ys[0] <= '0;
      zs[0] <= $signed({folded[PW-1], folded, {ZFRAC{1'b0}}});
    end
  end

  for (genvar i = 0; i < NSTG; i++) begin : g_rot
    localparam logic signed [ZW-1:0] ANG = ZW'(atanStep(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        xs[i+1] <= '0;
        ys[i+1] <= '0;
        zs[i+1] <= '0;
      end else if (!zs[i][ZW-1]) begin
        xs[i+1] <= xs[i] - (ys[i] >>> i);
        ys[i+1] <= ys[i] + (xs[i] >>> i);
        zs[i+1] <= zs[i] - ANG;
      end else begin
        xs[i+1] <= xs[i] + (ys[i] >>> i);
        ys[i+1] <= ys[i] - (xs[i] >>> i);
        zs[i+1] <= zs[i] + ANG;
      end
    end
  end

  function automatic logic signed [PW-1:0] clampOut(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] lim;
    lim = (v > POS_LIM) ? POS_LIM : ((v < NEG_LIM) ? NEG_LIM : v);
    return lim[FRAC +: PW];
  endfunction

  assign cosRaw = clampOut(xs[NSTG]);
  assign sinRaw = clampOut(ys[NSTG]);
endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  nco_strobe_t             strobes,
  output logic signed [SMP_W-1:0] cosOut,
  output logic signed [SMP_W-1:0] sinOut,
  output logic signed [SMP_W-1:0] toneOut,
  output logic [ACC_W-1:0]        accView,
  output logic                    scaleEnView,
  output logic signed [SMP_W+ASF_W:0] prodView,
  output logic                    toneModeView,
  output logic                    toneSineView
);
  localparam int PIPE = STAGES + 2;
  localparam int PRW  = SMP_W + ASF_W + 1;

  logic [ACC_W-1:0] accReg;
  logic [ACC_W-1:0] phaseFull;
  logic [SMP_W-1:0] phaseA;
  nco_side_t        sidePipe [PIPE];

  assign phaseFull = accReg + (ACC_W'(strobes.pow) << (ACC_W - OFS_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      accReg      <= '0;
      phaseA      <= '0;
      sidePipe[0] <= '0;
    end else begin
      accReg      <= accReg + strobes.ftw;
      phaseA      <= phaseFull[ACC_W-1 -: SMP_W];
      sidePipe[0] <= '{asf: strobes.asf, mulEn: strobes.mulEn,
                       singleTone: strobes.singleTone, toneSine: strobes.toneSine};
    end
  end

  for (genvar s = 1; s < PIPE; s++) begin : g_side
    always_ff @(posedge clk) begin
      if (rst) sidePipe[s] <= '0;
      else     sidePipe[s] <= sidePipe[s-1];
    end
  end

  logic signed [SMP_W-1:0] cosRaw, sinRaw;

  nco_cordic u_cordic (
    .clk    (clk),
    .rst    (rst),
    .phaseIn(phaseA),
    .cosRaw (cosRaw),
    .sinRaw (sinRaw)
  );

  nco_side_t               sideS;
  logic signed [PRW-1:0]   prodCos, prodSin;
  logic signed [SMP_W-1:0] passCos, passSin;
  logic signed [PRW-1:0]   scaleOp;

  assign scaleOp = $signed({{SMP_W{1'b0}}, sidePipe[PIPE-1].asf});

  // Product registers load only when the scaler is in use.
  always_ff @(posedge clk) begin
    if (rst) begin
      prodCos <= '0;
      prodSin <= '0;
    end else if (sidePipe[PIPE-1].mulEn) begin
      prodCos <= PRW'(cosRaw) * scaleOp;
      prodSin <= PRW'(sinRaw) * scaleOp;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      passCos <= '0;
      passSin <= '0;
      sideS   <= '0;
    end else begin
      passCos <= cosRaw;
      passSin <= sinRaw;
      sideS   <= sidePipe[PIPE-1];
    end
  end

  logic signed [SMP_W-1:0] cosSel, sinSel;
  assign cosSel = sideS.mulEn ? prodCos[ASF_W +: SMP_W] : passCos;
  assign sinSel = sideS.mulEn ? prodSin[ASF_W +: SMP_W] : passSin;

  always_ff @(posedge clk) begin
    if (rst) begin
      cosOut       <= '0;
      sinOut       <= '0;
      toneOut      <= '0;
      toneModeView <= 1'b0;
      toneSineView <= 1'b0;
    end else begin
      cosOut       <= cosSel;
      sinOut       <= sinSel;
      toneOut      <= sideS.singleTone ? (sideS.toneSine ? sinSel : cosSel) : '0;
      toneModeView <= sideS.singleTone;
      toneSineView <= sideS.toneSine;
    end
  end

  assign accView     = accReg;
  assign scaleEnView = sidePipe[PIPE-1].mulEn;
  assign prodView    = prodCos;
endmodule

// File: rtl/nco_tone_gen.sv
module nco_tone_gen
  import nco_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ACC_W-1:0]        wrData,
  input  logic [PROF_W-1:0]       profileSel,
  output logic signed [SMP_W-1:0] cosOut,
  output logic signed [SMP_W-1:0] sinOut,
  output logic signed [SMP_W-1:0] toneOut
);
  nco_strobe_t                 strobes;
  logic [ACC_W-1:0]            accView;
  logic                        scaleEnView;
  logic signed [SMP_W+ASF_W:0] prodView;
  logic                        toneModeView;
  logic                        toneSineView;

  nco_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .profileSel(profileSel),
    .strobes   (strobes)
  );

  nco_datapath u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .cosOut      (cosOut),
    .sinOut      (sinOut),
    .toneOut     (toneOut),
    .accView     (accView),
    .scaleEnView (scaleEnView),
    .prodView    (prodView),
    .toneModeView(toneModeView),
    .toneSineView(toneSineView)
  );
endmodule

// File: rtl/nco_tone_gen_checks.sv
module nco_tone_gen_checks
  import nco_pkg::*;
(
  input logic                    clk,
  input logic                    rst,
  input logic                    wrEn,
  input logic [ADDR_W-1:0]       wrAddr,
  input logic [ACC_W-1:0]        wrData,
  input logic [ACC_W-1:0]        ftw,
  input logic [ACC_W-1:0]        acc,
  input logic                    scaleEn,
  input logic signed [SMP_W+ASF_W:0] prod,
  input logic                    toneMode,
  input logic                    toneSine,
  input logic signed [SMP_W-1:0] cosOut,
  input logic signed [SMP_W-1:0] sinOut,
  input logic signed [SMP_W-1:0] toneOut
);
  logic primed = 1'b0;
  logic stepOk = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b1;
    stepOk <= primed & ~rst;
  end

  assert_acc_step_R1: assert property (@(posedge clk) disable iff (rst)
    stepOk |-> acc == $past(acc) + $past(ftw));

  assert_ftw_clip_R3: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_FTW) |=> ftw == {1'b0, $past(wrData[ACC_W-2:0])});

  assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !scaleEn |=> $stable(prod));

  assert_tone_route_R8: assert property (@(posedge clk) disable iff (rst)
    toneMode |-> toneOut == (toneSine ? sinOut : cosOut));

  assert_tone_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !toneMode |-> toneOut == '0);

  assert_reset_acc_R11: assert property (@(posedge clk)
    rst |=> acc == '0);
endmodule

bind nco_tone_gen nco_tone_gen_checks u_checks (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .ftw     (strobes.ftw),
  .acc     (accView),
  .scaleEn (scaleEnView),
  .prod    (prodView),
  .toneMode(toneModeView),
  .toneSine(toneSineView),
  .cosOut  (cosOut),
  .sinOut  (sinOut),
  .toneOut (toneOut)
);

// File: tb/nco_tone_gen_bench.sv
module nco_tone_gen_bench;
  localparam int LAT = 18;
  localparam real AMP = 32752.0;
  localparam real TOL = 12.0;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0] profileSel = '0;
  logic signed [15:0] cosOut, sinOut, toneOut;

  always #10 clk = ~clk;

  nco_tone_gen u_nco_tone_gen (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .profileSel(profileSel), .cosOut(cosOut), .sinOut(sinOut), .toneOut(toneOut)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit checking = 1'b0;
  string phaseTag = "R1";

  // Register model built from the write map.
  logic [31:0] accM, ftwM;
  logic bypM, toneM, sineM;
  logic [2:0] profM;
  logic [13:0] powM [8];
  logic [13:0] asfM [8];
  int runLen;

  always @(posedge clk) begin
    if (rst) begin
      accM <= '0; ftwM <= '0; bypM <= 1'b0; toneM <= 1'b0; sineM <= 1'b0;
      profM <= '0; runLen <= 0;
      for (int i = 0; i < 8; i++) begin powM[i] <= '0; asfM[i] <= '0; end
    end else begin
      accM <= accM + ftwM;
      runLen <= runLen + 1;
      profM <= profileSel;
      if (wrEn) begin
        if (wrAddr == 4'd0) ftwM <= {1'b0, wrData[30:0]};
        else if (wrAddr == 4'd1) begin
          bypM <= wrData[0]; toneM <= wrData[1]; sineM <= wrData[2];
        end else if (wrAddr[3]) begin
          powM[wrAddr[2:0]] <= wrData[13:0];
          asfM[wrAddr[2:0]] <= wrData[29:16];
        end
      end
    end
  end

  logic [15:0] hPhase [64];
  logic [13:0] hAsf [64];
  logic hByp [64];
  logic hTone [64];
  logic hSine [64];
  int negCnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic real expSample(input logic [15:0] ph, input bit sine,
                                    input bit byp, input logic [13:0] asf);
    real a, v;
    a = TWO_PI * real'(ph) / 65536.0;
    v = sine ? AMP * $sin(a) : AMP * $cos(a);
    if (!byp) v = v * real'(asf) / 16384.0;
    return v;
  endfunction

  function automatic bit near(input int act, input real exp);
    real d;
    d = real'(act) - exp;
    return (d <= TOL) && (d >= -TOL);
  endfunction

  always @(negedge clk) begin
    int idx, old;
    logic [31:0] ph32;
    real ec, es, et;
    idx = negCnt % 64;
    ph32 = accM + {powM[profM], 18'b0};
    hPhase[idx] = ph32[31:16];
    hAsf[idx] = asfM[profM];
    hByp[idx] = bypM;
    hTone[idx] = toneM;
    hSine[idx] = sineM;
    if (checking && !rst && runLen >= LAT) begin
      old = (negCnt - LAT) % 64;
      ec = expSample(hPhase[old], 1'b0, hByp[old], hAsf[old]);
      es = expSample(hPhase[old], 1'b1, hByp[old], hAsf[old]);
      check(near(cosOut, ec), {phaseTag, " R5"}, "cos", cosOut, $rtoi(ec));
      check(near(sinOut, es), hByp[old] ? "R4 R5" : "R4 R6", "sin", sinOut, $rtoi(es));
      if (hTone[old]) begin
        et = hSine[old] ? es : ec;
        check(near(toneOut, et), "R8", "tone", toneOut, $rtoi(et));
      end else
        check(toneOut == 0, "R9", "tone", toneOut, 0);
    end
    negCnt++;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    idle(6);
    // R11: reset drives every output to zero.
    check(cosOut == 0, "R11", "cos in reset", cosOut, 0);
    check(sinOut == 0, "R11", "sin in reset", sinOut, 0);
    check(toneOut == 0, "R11", "tone in reset", toneOut, 0);
    rst = 1'b0;
    checking = 1'b1;

    phaseTag = "R1";
    wr(4'd1, 32'h1);                 // bypass scaler, quadrature only
    wr(4'd0, 32'h556AAAAB);
    idle(80);
    wr(4'd1, 32'h3);                 // single tone, cosine
    idle(40);
    wr(4'd1, 32'h7);                 // single tone, sine
    idle(40);

    phaseTag = "R3";
    wr(4'd0, 32'hFFFF_FFFF);
    idle(60);
    wr(4'd0, 32'h8000_1234);
    idle(40);

    phaseTag = "R2";
    wr(4'd8, {2'b0, 14'h3FFF, 2'b0, 14'h0000});  // full scale, no offset
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h0123_4567);
    idle(50);
    wr(4'd8, {2'b0, 14'h0000, 2'b0, 14'h2000}); // zero scale, 180 deg offset
    idle(40);
    wr(4'd1, 32'h1);
    idle(40);

    phaseTag = "R10";
    wr(4'd0, 32'h0);                 // frozen phase: offset steps are visible
    for (int k = 0; k < 8; k++) wr(4'(8 + k), {2'b0, 14'(2000 * (k + 1)), 2'b0, 14'(k * 2048)});
    for (int k = 0; k < 8; k++) begin
      profileSel = 3'(k);
      idle(3);
    end
    wr(4'd0, 32'h1000_0000);
    wr(4'd0, 32'h0400_0000);
    idle(30);

    phaseTag = "R7";
    wr(4'd1, 32'h0);
    for (int n = 0; n < 400; n++) begin
      profileSel = 3'($urandom_range(0, 7));
      idle($urandom_range(1, 4));
    end

    phaseTag = "R2";
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) wr(4'd0, $urandom());
      else if (sel == 1) wr(4'd1, 32'($urandom_range(0, 7)));
      else wr(4'(8 + (sel - 2)), $urandom());
      if ($urandom_range(0, 3) == 0) profileSel = 3'($urandom_range(0, 7));
    end

    phaseTag = "R11";
    rst = 1'b1;
    idle(3);
    check(cosOut == 0, "R11", "cos after mid reset", cosOut, 0);
    rst = 1'b0;
    wr(4'd1, 32'h3);
    wr(4'd0, 32'h0800_0000);
    idle(60);

    idle(4);
    done = 1'b1;
    finishRun();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end
endmodule